// File: doc/BRIEF.md
# Triggered Window Sample Integrator

This block sums a continuous stream of signed 16-bit filter results, but only while an external trigger marks a window open. When the window opens, the running total is cleared. The block then adds a programmed number of valid samples, taking them as they arrive. When the last of those samples has been added, the total appears on the output together with a single-cycle valid pulse.

A typical use is removing a periodic carrier from a demodulated stream. If the window length equals one carrier period, the carrier's contribution sums to zero and only the slowly varying component remains. The same mechanism can capture a current measurement at a chosen point of a switching waveform.

Samples are ignored in three cases: while the window is closed, after the programmed count has been reached, and until the trigger returns to its inactive level and becomes active again. If a window closes before the count is reached, the partial total is thrown away and a status flag reports the short window.

Top module: `win_integrator`

## Requirements
- R1: After reset `sumValid` is 0, `windowShort` is 0 and `sumOut` is 0.
- R2: From idle, a window opens in the first cycle in which the trigger is at its active level. Opening a window clears the total, and a valid sample in that same cycle is the first sample added.
- R3: Each counted sample is sign-extended to the `sumOut` width and added. In the clock cycle after the edge that takes the N-th counted sample, `sumOut` holds the exact two's complement sum of the N samples and `sumValid` is 1 for exactly that one cycle.
- R4: Cycles inside a window with `sampleValid` = 0 are not counted, and their `sampleData` does not affect the sum.
- R5: After the count is reached, further samples are ignored. No second pulse occurs until the trigger goes inactive and then active again.
- R6: If the trigger goes inactive before N samples have been counted, there is no pulse, `sumOut` keeps its previous value and `windowShort` becomes 1. `windowShort` returns to 0 when the next window opens.
- R7: `trigActiveLow` = 0 makes a high trigger active, and 1 makes a low trigger active. The polarity is taken only while idle, so changing it inside a window has no effect on that window.
- R8: The count N is captured when the window opens. A `sampleCount` of 0 acts as 1, and values above `MAX_COUNT` act as `MAX_COUNT`.
- R9: Samples presented while the window is closed have no effect on the next window's sum.
- R10: A zero-mean periodic component whose period equals N contributes nothing to the sum, so only N times its DC offset remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Strobe marking a new result word |
| sampleData | input | SAMPLE_W | Signed result word |
| windowTrig | input | 1 | External window trigger |
| trigActiveLow | input | 1 | 1 selects a low active trigger level |
| sampleCount | input | CNT_W | Number of samples to add per window |
| sumOut | output | ACC_W | Last completed window total, signed |
| sumValid | output | 1 | One-cycle pulse when `sumOut` is updated |
| windowShort | output | 1 | The last window closed before its count was reached |

## Verification
A fault in the sample counter shows up in the first window as a pulse one or more samples early or late, or as no pulse at all. A fault in the accumulator shows up in the first window as a wrong `sumOut`. The bench sweeps every count from 0 past `MAX_COUNT`, using extreme, pseudo-random and gapped data, so an off-by-one error in either part appears at the first affected count. Faults in the state sequencing appear as a second pulse in the same window, as a missing or stuck `windowShort`, or as a window that ignores its polarity. Each of these is visible within a few cycles of the trigger edge that should have caused the change.

// File: rtl/win_integ_pkg.sv
package win_integ_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_HOLD  = 2'd2
  } winState_t;

  typedef struct packed {
    logic restart;   // clear total before adding this cycle
    logic take;      // add the current sample
    logic publish;   // copy the new total to the output
  } accStrobe_t;
endpackage

// File: rtl/win_integ_ctrl.sv
module win_integ_ctrl
  import win_integ_pkg::*;
#(
  parameter int MAX_COUNT = 16,
  parameter int CNT_W     = $clog2(MAX_COUNT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic               windowTrig,
  input  logic               trigActiveLow,
  input  logic [CNT_W-1:0]   sampleCount,
  output accStrobe_t         strobe,
  output logic               windowShort,
  output winState_t          stateNow
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_COUNT);

  winState_t        stateReg, stateNext;
  logic             polReg;
  logic [CNT_W-1:0] targetReg;
  logic [CNT_W-1:0] takenReg;
  logic             shortReg;

  logic             effPol;
  logic             winActive;
  logic             startWin;
  logic             inWin;
  logic             takeNow;
  logic             reached;
  logic [CNT_W-1:0] reqTarget;
  logic [CNT_W-1:0] effTarget;
  logic [CNT_W-1:0] takenBase;

  always_comb begin
    if (sampleCount == '0)          reqTarget = CNT_ONE;
    else if (sampleCount > CNT_MAX) reqTarget = CNT_MAX;
    else                            reqTarget = sampleCount;
  end

  assign effPol    = (stateReg == ST_IDLE) ? trigActiveLow : polReg;
  assign winActive = windowTrig ^ effPol;
  assign startWin  = (stateReg == ST_IDLE) && winActive;
  assign inWin     = startWin || ((stateReg == ST_ACCUM) && winActive);
  assign takeNow   = inWin && sampleValid;
  assign effTarget = startWin ? reqTarget : targetReg;
  assign takenBase = startWin ? '0 : takenReg;
  assign reached   = takeNow && ((takenBase + CNT_ONE) == effTarget);

  always_comb begin
    stateNext = stateReg;
    unique case (stateReg)
      ST_IDLE:  if (startWin) stateNext = reached ? ST_HOLD : ST_ACCUM;
      ST_ACCUM: if (!winActive) stateNext = ST_IDLE;
                else if (reached) stateNext = ST_HOLD;
      ST_HOLD:  if (!winActive) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg  <= ST_IDLE;
      polReg    <= 1'b0;
      targetReg <= CNT_ONE;
      takenReg  <= '0;
      shortReg  <= 1'b0;
    end else begin
      stateReg <= stateNext;
      if (stateReg == ST_IDLE) polReg <= trigActiveLow;
      if (startWin) begin
        targetReg <= reqTarget;
        takenReg  <= takeNow ? CNT_ONE : '0;
        shortReg  <= 1'b0;
      end else begin
        if (takeNow) takenReg <= takenReg + CNT_ONE;
        if ((stateReg == ST_ACCUM) && !winActive) shortReg <= 1'b1;
      end
    end
  end

  assign strobe.restart = startWin;
  assign strobe.take    = takeNow;
  assign strobe.publish = reached;
  assign windowShort    = shortReg;
  assign stateNow       = stateReg;
endmodule

// File: rtl/win_integ_dp.sv
module win_integ_dp
  import win_integ_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  accStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [ACC_W-1:0]    sumOut,
  output logic                sumValid
);
  localparam int EXT_W = ACC_W - SAMPLE_W;

  logic [ACC_W-1:0] accReg;
  logic [ACC_W-1:0] sampleExt;
  logic [ACC_W-1:0] accBase;
  logic [ACC_W-1:0] accNext;

  assign sampleExt = {{EXT_W{sampleData[SAMPLE_W-1]}}, sampleData};
  assign accBase   = strobe.restart ? '0 : accReg;
  assign accNext   = accBase + (strobe.take ? sampleExt : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg   <= '0;
      sumOut   <= '0;
      sumValid <= 1'b0;
    end else begin
      accReg   <= accNext;
      sumValid <= strobe.publish;
      if (strobe.publish) sumOut <= accNext;
    end
  end
endmodule

// File: rtl/win_integrator.sv
module win_integrator
  import win_integ_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int MAX_COUNT = 16,
  parameter int CNT_W     = $clog2(MAX_COUNT + 1),
  parameter int ACC_W     = SAMPLE_W + $clog2(MAX_COUNT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                windowTrig,
  input  logic                trigActiveLow,
  input  logic [CNT_W-1:0]    sampleCount,
  output logic [ACC_W-1:0]    sumOut,
  output logic                sumValid,
  output logic                windowShort
);
  accStrobe_t strobe;
  winState_t  stateNow;

  win_integ_ctrl #(.MAX_COUNT(MAX_COUNT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .windowTrig(windowTrig),
    .trigActiveLow(trigActiveLow), .sampleCount(sampleCount), .strobe(strobe),
    .windowShort(windowShort), .stateNow(stateNow)
  );

  win_integ_dp #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleData(sampleData),
    .sumOut(sumOut), .sumValid(sumValid)
  );
endmodule

// File: rtl/win_integ_chk.sv
module win_integ_chk
  import win_integ_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic [ACC_W-1:0] sumOut,
  input logic             sumValid,
  input logic             windowShort,
  input winState_t        stateNow
);
  // R3: a completed window yields a single-cycle pulse
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |=> !sumValid);

  // R6: the output total changes only together with the pulse
  assert_sum_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sumValid |-> $stable(sumOut));

  // R6: a short window never coincides with a completed one
  assert_short_no_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(windowShort) |-> (!sumValid && stateNow == ST_IDLE));

  // R2: the short flag clears only because a new window has opened
  assert_short_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(windowShort) |-> (stateNow != ST_IDLE));

  // R5: a pulse always leaves the block holding until the trigger drops
  assert_hold_after_R5: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> (stateNow == ST_HOLD || stateNow == ST_IDLE));
endmodule

bind win_integrator win_integ_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .sumOut(sumOut), .sumValid(sumValid),
  .windowShort(windowShort), .stateNow(stateNow)
);

// File: tb/tb_win_integrator.sv
module tb_win_integrator;
  localparam int SW = 16;
  localparam int MAXC = 16;
  localparam int CW = 5;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic          windowTrig = 1'b0;
  logic          trigActiveLow = 1'b0;
  logic [CW-1:0] sampleCount = '0;
  logic [AW-1:0] sumOut;
  logic          sumValid;
  logic          windowShort;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  longint lastSum = 0;
  int unsigned lcg = 32'h1234_5678;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  win_integrator dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .windowTrig(windowTrig), .trigActiveLow(trigActiveLow), .sampleCount(sampleCount),
    .sumOut(sumOut), .sumValid(sumValid), .windowShort(windowShort)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, observe result after the following edge
  task automatic drive(input bit v, input int d, input bit trg);
    sampleValid = v;
    sampleData  = SW'(d);
    windowTrig  = trg;
    @(negedge clk);
    if (sumValid) begin
      pulses++;
      lastSum = longint'($signed(sumOut));
    end
  endtask

  function automatic int nextRand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'($signed(lcg[31:16]));
  endfunction

  function automatic int clampCnt(input int c);
    if (c == 0) return 1;
    if (c > MAXC) return MAXC;
    return c;
  endfunction

  initial begin
    #1_600_000;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    fails++;
    checks++;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int d;
    int tgt;
    longint expSum;
    longint prevSum;
    @(negedge clk);
    @(negedge clk);
    check(sumValid == 0 && windowShort == 0 && sumOut == '0, "R1 reset outputs", longint'(sumOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // sweep every count 0..20 with four data patterns
    for (int c = 0; c <= 20; c++) begin
      for (int p = 0; p < 4; p++) begin
        tgt = clampCnt(c);
        sampleCount = CW'(c);
        // closed-window samples must be ignored (R9)
        drive(1, 32000, 0);
        drive(1, -31000, 0);
        pulses = 0;
        expSum = 0;
        for (int k = 0; k < tgt; k++) begin
          if (p == 0) d = 32767;
          else if (p == 1) d = -32768;
          else d = nextRand();
          if (p == 3 && k > 0) drive(0, 12345, 1); // gap, R4
          if (k == 1) sampleCount = CW'(3); // later change ignored, R8
          expSum += d;
          drive(1, d, 1);
        end
        check(pulses == 1, "R3 one pulse per window", pulses, 1);
        check(lastSum == expSum, "R3 R4 R8 R9 window sum", lastSum, expSum);
        for (int k = 0; k < 3; k++) drive(1, 999, 1); // extra samples, R5
        check(pulses == 1, "R5 no extra pulse", pulses, 1);
        check(windowShort == 0, "R5 complete window not short", windowShort, 0);
        drive(0, 0, 0);
      end
    end

    // early close
    prevSum = lastSum;
    sampleCount = CW'(8);
    pulses = 0;
    for (int k = 0; k < 5; k++) drive(1, 1000 + k, 1);
    drive(0, 0, 0);
    check(windowShort == 1, "R6 short flag set", windowShort, 1);
    check(pulses == 0, "R6 no pulse on short window", pulses, 0);
    check(longint'($signed(sumOut)) == prevSum, "R6 sumOut held", longint'($signed(sumOut)), prevSum);
    drive(0, 0, 0);
    drive(0, 0, 1);
    check(windowShort == 0, "R2 short cleared on open", windowShort, 0);
    for (int k = 0; k < 8; k++) drive(1, 10, 1);
    check(lastSum == 80 && pulses == 1, "R2 fresh sum after short window", lastSum, 80);
    drive(0, 0, 0);

    // active-low polarity: select while trigger high (inactive for the new level)
    trigActiveLow = 1'b1;
    drive(0, 0, 1);
    drive(0, 0, 1);
    pulses = 0;
    sampleCount = CW'(4);
    for (int k = 0; k < 4; k++) drive(1, -500 * (k + 1), 0);
    check(pulses == 1 && lastSum == -5000, "R7 active-low window", lastSum, -5000);
    drive(0, 0, 1);
    check(windowShort == 0, "R7 active-low idle", windowShort, 0);
    // polarity change inside a window is ignored
    trigActiveLow = 1'b0;
    drive(0, 0, 0);
    pulses = 0;
    sampleCount = CW'(6);
    drive(1, 7, 1);
    trigActiveLow = 1'b1;
    for (int k = 0; k < 5; k++) drive(1, 7, 1);
    check(pulses == 1 && lastSum == 42, "R7 polarity held in window", lastSum, 42);
    trigActiveLow = 1'b0;
    drive(0, 0, 0);

    // carrier cancellation over one period of 8
    pulses = 0;
    sampleCount = CW'(8);
    for (int k = 0; k < 8; k++) begin
      case (k)
        0: d = 0;      1: d = 7071;   2: d = 10000;  3: d = 7071;
        4: d = 0;      5: d = -7071;  6: d = -10000; default: d = -7071;
      endcase
      drive(1, d + 123, 1);
    end
    check(pulses == 1 && lastSum == 984, "R10 carrier cancelled", lastSum, 984);
    drive(0, 0, 0);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule